// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block collects every reset request of a small microcontroller and turns them into one system reset. The requests are a power-on event, a supply-monitor power-fail flag, an external active-low reset pin, a conversion-start strobe, a one-cycle software reset pulse, a comparator output, a missing-clock flag and a watchdog expiry. The conversion-start, comparator and supply-fail requests each pass through their own enable input. Every asynchronous request goes through a two-flop synchronizer before it is merged. Power-on acts asynchronously.

A supply reset (power-on or an enabled power-fail) also pulls the shared reset pin low. The pin stays low until a down-counter of `PIN_TMO` cycles runs out. The block ignores the pin's own low level while it drives the pin and for a short time afterwards. Any other request holds reset for a stretch of at least `MIN_STRETCH` cycles. The system reset is released only when the system clock source reports that it is stable. During reset the block offers the defaults that other logic loads: port latches all ones, reset vector zero, internal oscillator at its slowest divider, and watchdog enabled at its longest interval. A sticky flag register records the source or sources of the latest reset.

The controller has four states. `ST_PIN_HOLD` drives the pin and runs the pin timeout. `ST_STRETCH` holds reset for non-supply sources. `ST_WAIT_CLK` waits for a stable clock. `ST_RUN` is normal operation. The transitions are:
- Power-on leads to `ST_PIN_HOLD`.
- A supply request from any state leads to `ST_PIN_HOLD`.
- Another request leads from `ST_RUN` or `ST_WAIT_CLK` to `ST_STRETCH`.
- `ST_PIN_HOLD` moves to `ST_WAIT_CLK` when the timeout expires.
- `ST_STRETCH` moves to `ST_WAIT_CLK` when the stretch ends.
- `ST_WAIT_CLK` moves to `ST_RUN` when the clock is stable.

Top module: `rstctl_top`

## Requirements
- R1: While `por_n` is low, `sys_rst` and `rst_pin_pull_low` are 1 and `reset_src` is 8'h01, with no clock edge needed.
- R2: After `por_n` rises, `rst_pin_pull_low` stays 1 for exactly `PIN_TMO` cycles and `sys_rst` for `PIN_TMO`+1 cycles. The `rst_pin_pull_low` output is 1 only for supply resets.
- R3: A low level on `rst_pin_in` from outside resets the chip and sets flag bit 2. The block's own drive of the pin is never flagged as a pin reset.
- R4: The conversion-start, comparator and supply-fail requests cause no reset and leave `reset_src` unchanged while their enable is 0.
- R5: A one-cycle `sw_rst_pulse` holds `sys_rst` for `MIN_STRETCH`+1 cycles when the clock is stable. An asynchronous non-supply request held for 3 cycles gives `MIN_STRETCH`+3 cycles.
- R6: `sys_rst` stays 1 while `clk_stable` is 0 and falls one cycle after `clk_stable` rises.
- R7: `reset_src` bits are: 0 power-on, 1 supply fail, 2 pin, 3 conversion start, 4 software, 5 comparator, 6 missing clock, 7 watchdog. The register is rewritten with the requests present when reset starts, ORs in further requests while reset lasts, and holds its value after release.
- R8: `port_latch_load` equals `sys_rst`. The default values are: `port_latch_value`=8'hFF, `pc_reset_vector`=0, `clk_src_sel`=0 (internal), `osc_div_sel`=2'b11 (slowest), `wdt_enable`=1 and `wdt_interval_sel`=2'b11 (longest).
- R9: The missing-clock and watchdog requests always cause a reset, whatever the enables.
- R10: A supply-fail request held for 3 cycles keeps `rst_pin_pull_low` at 1 for `PIN_TMO`+2 cycles and `sys_rst` for `PIN_TMO`+3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| supply_fail | input | 1 | Supply-monitor power-fail flag |
| supmon_rst_en | input | 1 | Enable for power-fail reset |
| rst_pin_in | input | 1 | Level seen on the shared reset pin, active low |
| conv_strobe | input | 1 | Conversion-start strobe |
| conv_rst_en | input | 1 | Enable for conversion-start reset |
| sw_rst_pulse | input | 1 | One-cycle software reset command |
| cmp_out | input | 1 | Comparator output |
| cmp_rst_en | input | 1 | Enable for comparator reset |
| clk_missing | input | 1 | Missing-clock detector flag |
| wdt_expire | input | 1 | Watchdog timeout |
| clk_stable | input | 1 | System clock source is stable |
| sys_rst | output | 1 | System reset, active high |
| rst_pin_pull_low | output | 1 | Open-drain pull-down for the reset pin |
| reset_src | output | 8 | Sticky reset source flags |
| port_latch_load | output | 1 | Load default into port latches |
| port_latch_value | output | PORT_W | Port latch default |
| pc_reset_vector | output | PC_W | Program counter start address |
| clk_src_sel | output | 1 | Clock source default (0 internal) |
| osc_div_sel | output | 2 | Oscillator divider default |
| wdt_enable | output | 1 | Watchdog enable default |
| wdt_interval_sel | output | 2 | Watchdog interval default |

## Verification
The bench sweeps each of the seven non-power-on sources with its enable both off and on, driving the request for a fixed length. It checks the reset length, the pin drive and the flag value. This separates gated sources from always-active ones, supply resets that drive the pin from those that do not, and synchronized level requests from the unsynchronized one-cycle software pulse. Three further cases are tried separately:
- a release held back by an unstable clock
- two sources firing at once, which shows that flags accumulate
- an asynchronous power-on during normal operation, which shows that reset asserts without a clock edge

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
    typedef enum logic [1:0] {
        ST_PIN_HOLD = 2'd0,
        ST_STRETCH  = 2'd1,
        ST_WAIT_CLK = 2'd2,
        ST_RUN      = 2'd3
    } rst_state_e;

    localparam int SRC_N    = 8;
    localparam int SRC_POR  = 0;
    localparam int SRC_SUPF = 1;
    localparam int SRC_PIN  = 2;
    localparam int SRC_CONV = 3;
    localparam int SRC_SW   = 4;
    localparam int SRC_CMP  = 5;
    localparam int SRC_MCD  = 6;
    localparam int SRC_WDT  = 7;

    localparam int SYNC_N    = 6;
    localparam int SY_SUPF   = 0;
    localparam int SY_PIN    = 1;
    localparam int SY_CONV   = 2;
    localparam int SY_CMP    = 3;
    localparam int SY_MCD    = 4;
    localparam int SY_WDT    = 5;
    localparam int PIN_MASK_LEN = 3;
endpackage

// File: rtl/rstctl_sync.sv
module rstctl_sync #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/rstctl_fsm.sv
module rstctl_fsm
    import rstctl_pkg::*;
#(
    parameter int PIN_TMO     = 100,
    parameter int MIN_STRETCH = 4
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       supply_req,
    input  logic       other_req,
    input  logic       clk_stable,
    output rst_state_e state,
    output logic       sys_rst,
    output logic       pin_low
);
    localparam int CNT_MAX = (PIN_TMO > MIN_STRETCH) ? PIN_TMO : MIN_STRETCH;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] PIN_LOAD = CW'(PIN_TMO - 1);
    localparam logic [CW-1:0] STR_LOAD = CW'(MIN_STRETCH - 1);

    rst_state_e    state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_PIN_HOLD: begin
                if (supply_req)         cnt_nxt = PIN_LOAD;
                else if (cnt != '0)     cnt_nxt = cnt - 1'b1;
                else                    state_nxt = ST_WAIT_CLK;
            end
            ST_STRETCH: begin
                if (supply_req) begin
                    state_nxt = ST_PIN_HOLD;
                    cnt_nxt   = PIN_LOAD;
                end else if (other_req) cnt_nxt = STR_LOAD;
                else if (cnt != '0)     cnt_nxt = cnt - 1'b1;
                else                    state_nxt = ST_WAIT_CLK;
            end
            ST_WAIT_CLK, ST_RUN: begin
                if (supply_req) begin
                    state_nxt = ST_PIN_HOLD;
                    cnt_nxt   = PIN_LOAD;
                end else if (other_req) begin
                    state_nxt = ST_STRETCH;
                    cnt_nxt   = STR_LOAD;
                end else if (state == ST_WAIT_CLK && clk_stable) begin
                    state_nxt = ST_RUN;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= ST_PIN_HOLD;
            cnt   <= PIN_LOAD;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        sys_rst = (state != ST_RUN);
        pin_low = (state == ST_PIN_HOLD);
    end

    AST_PIN_ONLY_SUPPLY: assert property (@(posedge clk) disable iff (!por_n)
        $rose(pin_low) |-> $past(supply_req)); // R2
    AST_RUN_NEEDS_CLK: assert property (@(posedge clk) disable iff (!por_n)
        (state != ST_RUN && !clk_stable) |=> (state != ST_RUN)); // R6
    AST_STRETCH_ENTRY: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_RUN && other_req && !supply_req) |=> (state == ST_STRETCH)); // R5
    AST_STRETCH_BOUND: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_STRETCH) |-> (cnt < CW'(MIN_STRETCH))); // R5
endmodule

// File: rtl/rstctl_flags.sv
module rstctl_flags
    import rstctl_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             in_run,
    input  logic [SRC_N-1:0] req,
    output logic [SRC_N-1:0] flags
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flags <= SRC_N'(1) << SRC_POR;
        end else if (in_run) begin
            if (|req) flags <= req;
        end else begin
            flags <= flags | req;
        end
    end

    AST_FLAGS_NONZERO: assert property (@(posedge clk) disable iff (!por_n)
        flags != '0); // R7
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int PIN_TMO     = 100,
    parameter int MIN_STRETCH = 4,
    parameter int PORT_W      = 8,
    parameter int PC_W        = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              supply_fail,
    input  logic              supmon_rst_en,
    input  logic              rst_pin_in,
    input  logic              conv_strobe,
    input  logic              conv_rst_en,
    input  logic              sw_rst_pulse,
    input  logic              cmp_out,
    input  logic              cmp_rst_en,
    input  logic              clk_missing,
    input  logic              wdt_expire,
    input  logic              clk_stable,
    output logic              sys_rst,
    output logic              rst_pin_pull_low,
    output logic [SRC_N-1:0]  reset_src,
    output logic              port_latch_load,
    output logic [PORT_W-1:0] port_latch_value,
    output logic [PC_W-1:0]   pc_reset_vector,
    output logic              clk_src_sel,
    output logic [1:0]        osc_div_sel,
    output logic              wdt_enable,
    output logic [1:0]        wdt_interval_sel
);
    logic [SYNC_N-1:0]       raw, syn;
    logic [SRC_N-1:0]        req;
    logic [PIN_MASK_LEN-1:0] drive_hist;
    logic                    own_drive;
    rst_state_e              state;
    logic                    pin_low;

    always_comb begin
        raw          = '0;
        raw[SY_SUPF] = supply_fail;
        raw[SY_PIN]  = ~rst_pin_in;
        raw[SY_CONV] = conv_strobe;
        raw[SY_CMP]  = cmp_out;
        raw[SY_MCD]  = clk_missing;
        raw[SY_WDT]  = wdt_expire;
    end

    rstctl_sync #(.N(SYNC_N)) u_sync (
        .clk(clk), .rst_n(por_n), .d(raw), .q(syn)
    );

    // Pin level is masked while and shortly after this block drives it
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) drive_hist <= '1;
        else        drive_hist <= {drive_hist[PIN_MASK_LEN-2:0], pin_low};
    end
    assign own_drive = pin_low | (|drive_hist);

    always_comb begin
        req           = '0;
        req[SRC_SUPF] = syn[SY_SUPF] & supmon_rst_en;
        req[SRC_PIN]  = syn[SY_PIN] & ~own_drive;
        req[SRC_CONV] = syn[SY_CONV] & conv_rst_en;
        req[SRC_SW]   = sw_rst_pulse;
        req[SRC_CMP]  = syn[SY_CMP] & cmp_rst_en;
        req[SRC_MCD]  = syn[SY_MCD];
        req[SRC_WDT]  = syn[SY_WDT];
    end

    rstctl_fsm #(.PIN_TMO(PIN_TMO), .MIN_STRETCH(MIN_STRETCH)) u_fsm (
        .clk(clk), .por_n(por_n),
        .supply_req(req[SRC_SUPF]),
        .other_req(|req[SRC_N-1:SRC_PIN]),
        .clk_stable(clk_stable),
        .state(state), .sys_rst(sys_rst), .pin_low(pin_low)
    );

    rstctl_flags u_flags (
        .clk(clk), .por_n(por_n), .in_run(state == ST_RUN),
        .req(req), .flags(reset_src)
    );

    always_comb begin
        rst_pin_pull_low = pin_low;
        port_latch_load  = sys_rst;
        port_latch_value = '1;
        pc_reset_vector  = '0;
        clk_src_sel      = 1'b0;
        osc_div_sel      = 2'b11;
        wdt_enable       = 1'b1;
        wdt_interval_sel = 2'b11;
    end

    AST_OWN_PIN_NOT_FLAGGED: assert property (@(posedge clk) disable iff (!por_n)
        rst_pin_pull_low |=> !reset_src[SRC_PIN] || $past(reset_src[SRC_PIN])); // R3
endmodule

// File: tb/rstctl_top_bench.sv
module rstctl_top_bench;
    localparam int P  = 12;
    localparam int MS = 4;

    logic clk = 1'b0;
    logic por_n, supply_fail, supmon_rst_en, ext_n, conv_strobe, conv_rst_en;
    logic sw_rst_pulse, cmp_out, cmp_rst_en, clk_missing, wdt_expire, clk_stable;
    logic sys_rst, rst_pin_pull_low, port_latch_load, clk_src_sel, wdt_enable;
    logic [7:0]  reset_src, port_latch_value;
    logic [15:0] pc_reset_vector;
    logic [1:0]  osc_div_sel, wdt_interval_sel;
    logic rst_pin_in;
    int checks = 0, errors = 0;
    bit done = 0;

    assign rst_pin_in = rst_pin_pull_low ? 1'b0 : ext_n;

    always #5 clk = ~clk;

    rstctl_top #(.PIN_TMO(P), .MIN_STRETCH(MS)) u_rstctl_top (
        .clk(clk), .por_n(por_n), .supply_fail(supply_fail),
        .supmon_rst_en(supmon_rst_en), .rst_pin_in(rst_pin_in),
        .conv_strobe(conv_strobe), .conv_rst_en(conv_rst_en),
        .sw_rst_pulse(sw_rst_pulse), .cmp_out(cmp_out), .cmp_rst_en(cmp_rst_en),
        .clk_missing(clk_missing), .wdt_expire(wdt_expire), .clk_stable(clk_stable),
        .sys_rst(sys_rst), .rst_pin_pull_low(rst_pin_pull_low), .reset_src(reset_src),
        .port_latch_load(port_latch_load), .port_latch_value(port_latch_value),
        .pc_reset_vector(pc_reset_vector), .clk_src_sel(clk_src_sel),
        .osc_div_sel(osc_div_sel), .wdt_enable(wdt_enable),
        .wdt_interval_sel(wdt_interval_sel)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_src(input int src, input logic v);
        case (src)
            1: supply_fail = v;
            2: ext_n       = ~v;
            3: conv_strobe = v;
            4: sw_rst_pulse = v;
            5: cmp_out     = v;
            6: clk_missing = v;
            default: wdt_expire = v;
        endcase
    endtask

    task automatic check_defaults(input string tag);
        chk(port_latch_load == sys_rst, tag, port_latch_load, sys_rst);
        chk(port_latch_value == 8'hFF && pc_reset_vector == 16'h0 && clk_src_sel == 1'b0
            && osc_div_sel == 2'b11 && wdt_enable && wdt_interval_sel == 2'b11,
            tag, port_latch_value, 255);
    endtask

    task automatic run_src(input int src, input bit en);
        logic [7:0] prev;
        int cs, cp, exp_cs, exp_cp;
        bit gated, fires;
        prev = reset_src;
        supmon_rst_en = en; conv_rst_en = en; cmp_rst_en = en;
        @(negedge clk);
        cs = 0; cp = 0;
        for (int i = 0; i < 60; i++) begin
            set_src(src, (src == 4) ? (i == 0) : (i < 3));
            @(posedge clk);
            @(negedge clk);
            if (sys_rst) cs++;
            if (rst_pin_pull_low) cp++;
        end
        gated = (src == 1 || src == 3 || src == 5);
        fires = !gated || en;
        if (!fires) begin
            chk(cs == 0, "R4 gated no reset", cs, 0);
            chk(reset_src == prev, "R4 flags kept", reset_src, prev);
        end else begin
            if (src == 1) begin exp_cp = P + 2; exp_cs = P + 3; end
            else if (src == 4) begin exp_cp = 0; exp_cs = MS + 1; end
            else begin exp_cp = 0; exp_cs = MS + 3; end
            if (src == 1) chk(cs == exp_cs && cp == exp_cp, "R10 supply length", cs*100+cp, exp_cs*100+exp_cp);
            else if (src == 4) chk(cs == exp_cs, "R5 sw stretch", cs, exp_cs);
            else chk(cs == exp_cs, "R5 async stretch", cs, exp_cs);
            chk(cp == exp_cp, "R2 pin drive only for supply", cp, exp_cp);
            chk(reset_src == (8'h1 << src), "R7 source flag", reset_src, 1 << src);
            if (src == 2) chk(reset_src[2], "R3 pin flag", reset_src, 4);
            if (src >= 6) chk(cs > 0, "R9 always active", cs, exp_cs);
        end
        chk(!sys_rst, "R6 released", sys_rst, 0);
    endtask

    initial begin
        int cnt = 0;
        while (!done && cnt < 100000) begin
            @(posedge clk);
            cnt++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cnt, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cs, cp;
        por_n = 0; supply_fail = 0; supmon_rst_en = 0; ext_n = 1; conv_strobe = 0;
        conv_rst_en = 0; sw_rst_pulse = 0; cmp_out = 0; cmp_rst_en = 0;
        clk_missing = 0; wdt_expire = 0; clk_stable = 1;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(sys_rst && rst_pin_pull_low, "R1 reset outputs", {sys_rst, rst_pin_pull_low}, 3);
        chk(reset_src == 8'h01, "R1 por flag", reset_src, 1);
        check_defaults("R8 defaults in reset");

        // R2 power-on pin timeout
        por_n = 1;
        cs = 0; cp = 0;
        while (sys_rst && cs < 500) begin
            if (sys_rst) cs++;
            if (rst_pin_pull_low) cp++;
            @(negedge clk);
        end
        chk(cp == P, "R2 pin low cycles", cp, P);
        chk(cs == P + 1, "R2 reset cycles", cs, P + 1);
        chk(reset_src == 8'h01, "R7 por flag kept", reset_src, 1);
        check_defaults("R8 defaults in run");

        // Source sweep
        for (int src = 1; src < 8; src++)
            for (int en = 0; en < 2; en++)
                run_src(src, en[0]);

        // R6 release waits for stable clock
        clk_stable = 0;
        for (int i = 0; i < 3; i++) begin wdt_expire = 1; @(negedge clk); end
        wdt_expire = 0;
        repeat (30) @(negedge clk);
        chk(sys_rst, "R6 held while clock unstable", sys_rst, 1);
        clk_stable = 1;
        @(negedge clk);
        chk(!sys_rst, "R6 release after stable", sys_rst, 0);
        chk(reset_src == 8'h80, "R7 watchdog flag", reset_src, 8'h80);

        // R7 accumulate two sources
        clk_missing = 1; wdt_expire = 1;
        repeat (3) @(negedge clk);
        clk_missing = 0; wdt_expire = 0;
        repeat (20) @(negedge clk);
        chk(reset_src == 8'hC0, "R7 two sources", reset_src, 8'hC0);

        // R1 asynchronous power-on during run
        chk(!sys_rst, "R1 running before por", sys_rst, 0);
        #2 por_n = 0;
        #1;
        chk(sys_rst && rst_pin_pull_low && reset_src == 8'h01, "R1 async assert",
            reset_src, 1);
        @(negedge clk);
        por_n = 1;
        repeat (P + 4) @(negedge clk);
        chk(!sys_rst, "R2 release after por", sys_rst, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule